// File: doc/BRIEF.md
# Mode-Selectable Serial/Parallel Shift Register

A small storage register whose transfer style is set by a two-bit mode input. Data can enter one bit at a time or as a whole word, and it can leave one bit at a time or as a whole word. The four combinations give four styles. Every stage is a flip-flop with a four-way selector in front of it. A separate load strobe captures a parallel word in the two parallel-input styles.

Serial data moves downward. It enters at the top stage and leaves from bit 0, so a stream sent least-significant bit first is in natural order after one word of clocks. A sequence counter counts the shifts made since the last load or mode change. After a full word of shifts it raises a completion flag. In serial-in/parallel-out use the flag means the word is assembled. In parallel-in/serial-out use it means the word has been fully sent. Stored data stays in place across a mode change until a new shift or load acts on it.

Top module: `mode_sel_shift_reg`

## Requirements
- R1: While `rst_ni` is low, all stages, the shift counter and `done_o` are cleared, so `par_o`, `serial_o` and `done_o` read 0.
- R2: Mode code 2'b00 (serial in, serial out): on each clock every stored bit moves one place toward bit 0, `serial_i` enters bit WIDTH-1, and `serial_o` always shows bit 0. A bit therefore reaches `serial_o` WIDTH clocks after it enters.
- R3: Mode code 2'b01 (serial in, parallel out): the register shifts as in R2. After WIDTH clocks, `par_o` holds the last WIDTH serial bits, with the first bit of them at bit 0.
- R4: In modes 2'b00 and 2'b01, `load_i` has no effect on the data, the shift or the counter.
- R5: Mode code 2'b10 (parallel in, serial out): a clock with `load_i` high copies `par_i` into all stages, and it is visible on `par_o` after that edge.
- R6: In mode 2'b10 with `load_i` low, each clock shifts toward bit 0 and fills the top stage with 0. A loaded word leaves on `serial_o` bit 0 first, and the register reads zero after WIDTH clocks.
- R7: Mode code 2'b11 (parallel in, parallel out): a clock with `load_i` high writes `par_i` into every stage, and `par_o` shows it from the next cycle. With `load_i` low the contents hold, and `serial_i` is ignored.
- R8: Register contents carry over a mode change unchanged until the new mode shifts or loads.
- R9: `done_o` rises on the clock that completes the WIDTH-th shift since the last restart, and it then stays high. A restart is a load in a parallel-in mode or any change of mode code. A restart clears `done_o`. If the restart clock also shifts, that shift counts as the first.
- R10: In mode 2'b11 no shift takes place, so `done_o` stays low after any load or mode change into that mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Transfer style code |
| load_i | input | 1 | Parallel capture strobe |
| serial_i | input | 1 | Serial data in, enters the top stage |
| par_i | input | WIDTH | Parallel data in |
| serial_o | output | 1 | Serial data out, bit 0 of the register |
| par_o | output | WIDTH | Parallel view of all stages |
| done_o | output | 1 | A full word of shifts has been made since the last restart |

## Verification
The hardest case to reach is the meeting of a restart and a shift in the same clock. A mode change into a shifting mode must restart the count and also count that edge's shift. Clearing the flag alone is not enough. The sweep reaches this case by moving from parallel hold straight into a serial mode and from a serial fill straight into the serial drain mode. The flag timing is then checked against a count made in the bench. Every one of the sixteen words passes through all four modes with toggled load and serial inputs. This shows that the ignored inputs leave the ports unchanged.

// File: rtl/msr_pkg.sv
package msr_pkg;

  localparam logic [1:0] MODE_SISO = 2'b00;
  localparam logic [1:0] MODE_SIPO = 2'b01;
  localparam logic [1:0] MODE_PISO = 2'b10;
  localparam logic [1:0] MODE_PIPO = 2'b11;

  typedef enum logic [1:0] {
    SEL_HOLD  = 2'd0,
    SEL_SHIFT = 2'd1,
    SEL_LOAD  = 2'd2,
    SEL_CLEAR = 2'd3
  } stage_sel_e;

endpackage

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       load_i,
  input  logic       serial_i,
  output stage_sel_e sel_o,
  output logic       fill_o,
  output logic       shift_o,
  output logic       restart_o
);

  logic [1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_SISO;
    else         mode_q <= mode_i;
  end

  always_comb begin
    sel_o   = SEL_HOLD;
    fill_o  = 1'b0;
    shift_o = 1'b0;
    case (mode_i)
      MODE_SISO, MODE_SIPO: begin
        sel_o   = SEL_SHIFT;
        fill_o  = serial_i;
        shift_o = 1'b1;
      end
      MODE_PISO: begin
        sel_o   = load_i ? SEL_LOAD : SEL_SHIFT;
        shift_o = !load_i;
      end
      default: sel_o = load_i ? SEL_LOAD : SEL_HOLD;
    endcase
  end

  assign restart_o = (mode_i != mode_q) || (mode_i[1] && load_i);

endmodule

// File: rtl/msr_stage.sv
module msr_stage
  import msr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  stage_sel_e sel_i,
  input  logic       shift_src_i,
  input  logic       par_bit_i,
  output logic       q_o
);

  logic d;

  always_comb begin
    case (sel_i)
      SEL_SHIFT: d = shift_src_i;
      SEL_LOAD:  d = par_bit_i;
      SEL_CLEAR: d = 1'b0;
      default:   d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end

endmodule

// File: rtl/msr_seq_count.sv
module msr_seq_count #(
  parameter int unsigned WIDTH = 4,
  localparam int unsigned CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic restart_i,
  output logic done_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (restart_i) begin
      // shift made on the restart edge counts as the first
      cnt_q  <= shift_i ? CNT_W'(1) : '0;
      done_o <= 1'b0;
    end else if (shift_i) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        done_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/mode_sel_shift_reg.sv
module mode_sel_shift_reg
  import msr_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             load_i,
  input  logic             serial_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             serial_o,
  output logic [WIDTH-1:0] par_o,
  output logic             done_o
);

  stage_sel_e sel;
  logic       fill;
  logic       shift_evt;
  logic       restart_evt;
  logic [WIDTH-1:0] q;

  msr_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .load_i   (load_i),
    .serial_i (serial_i),
    .sel_o    (sel),
    .fill_o   (fill),
    .shift_o  (shift_evt),
    .restart_o(restart_evt)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic src;
    if (i == WIDTH - 1) begin : g_top
      assign src = fill;
    end else begin : g_mid
      assign src = q[i+1];
    end
    msr_stage u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (sel),
      .shift_src_i(src),
      .par_bit_i  (par_i[i]),
      .q_o        (q[i])
    );
  end

  msr_seq_count #(.WIDTH(WIDTH)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (shift_evt),
    .restart_i(restart_evt),
    .done_o   (done_o)
  );

  assign par_o    = q;
  assign serial_o = q[0];

endmodule

// File: rtl/msr_checks.sv
module msr_checks #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             load_i,
  input logic             serial_i,
  input logic [WIDTH-1:0] par_i,
  input logic             serial_o,
  input logic [WIDTH-1:0] par_o,
  input logic             done_o
);

  a_r2_serial_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serial_o == par_o[0]);

  a_r2_serial_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[1] |=> par_o == {$past(serial_i), $past(par_o[WIDTH-1:1])});

  a_r5_load_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && load_i) |=> par_o == $past(par_i));

  a_r6_drain_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && !load_i) |=> par_o == {1'b0, $past(par_o[WIDTH-1:1])});

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !load_i) |=> $stable(par_o));

  a_r9_load_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && load_i) |=> !done_o);

  a_r10_no_done_in_pipo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !done_o) |=> !done_o);

endmodule

bind mode_sel_shift_reg msr_checks #(.WIDTH(WIDTH)) u_checks (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_i),
  .load_i  (load_i),
  .serial_i(serial_i),
  .par_i   (par_i),
  .serial_o(serial_o),
  .par_o   (par_o),
  .done_o  (done_o)
);

// File: tb/mode_sel_shift_reg_bench.sv
module mode_sel_shift_reg_bench;

  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic         load_i = 1'b0;
  logic         serial_i = 1'b0;
  logic [W-1:0] par_i = '0;
  logic         serial_o;
  logic [W-1:0] par_o;
  logic         done_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench model state
  logic [W-1:0] m_q = '0;
  int           m_cnt = 0;
  logic         m_done = 1'b0;
  logic [1:0]   m_mode = 2'b00;

  always #10 clk_i = ~clk_i;

  mode_sel_shift_reg #(.WIDTH(W)) u_mode_sel_shift_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .load_i  (load_i),
    .serial_i(serial_i),
    .par_i   (par_i),
    .serial_o(serial_o),
    .par_o   (par_o),
    .done_o  (done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // one clock with given inputs; expected state follows the requirements
  task automatic step(input logic [1:0] m, input logic ld, input logic si,
                      input logic [W-1:0] pi, input string req);
    logic shift;
    logic restart;
    mode_i = m; load_i = ld; serial_i = si; par_i = pi;
    shift   = !m[1] || (m == 2'b10 && !ld);
    restart = (m != m_mode) || (m[1] && ld);
    @(posedge clk_i);
    if (m[1] && ld)     m_q = pi;
    else if (m == 2'b10) m_q = {1'b0, m_q[W-1:1]};
    else if (!m[1])     m_q = {si, m_q[W-1:1]};
    if (restart) begin
      m_cnt  = shift ? 1 : 0;
      m_done = 1'b0;
    end else if (shift) begin
      m_cnt = m_cnt + 1;
      if (m_cnt == W) begin
        m_cnt  = 0;
        m_done = 1'b1;
      end
    end
    m_mode = m;
    @(negedge clk_i);
    check({req, " par_o"}, int'(par_o), int'(m_q));
    check({req, " serial_o"}, int'(serial_o), int'(m_q[0]));
    check({req, " done_o"}, int'(done_o), int'(m_done));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    check("R1 par_o", int'(par_o), 0);
    check("R1 serial_o", int'(serial_o), 0);
    check("R1 done_o", int'(done_o), 0);
    rst_ni = 1'b1;

    for (int w = 0; w < 16; w++) begin
      logic [W-1:0] word;
      logic [W-1:0] inv;
      word = W'(w);
      inv  = ~word;

      // R3 serial fill, LSB first; R4 load toggled with no effect
      for (int k = 0; k < W; k++)
        step(2'b01, k[0], word[k], inv, "R3 R4 fill");
      check("R3 word assembled", int'(par_o), w);
      check("R9 done after fill", int'(done_o), 1);

      // R8 contents persist into PIPO without load; R10 no done
      step(2'b11, 1'b0, ~word[0], inv, "R8 R10 mode change hold");
      check("R8 persisted", int'(par_o), w);
      check("R10 done low", int'(done_o), 0);

      // R5 load then R6 drain
      step(2'b10, 1'b1, 1'b1, inv, "R5 load");
      check("R5 captured", int'(par_o), int'(inv));
      for (int k = 1; k <= W; k++) begin
        step(2'b10, 1'b0, 1'b1, word, "R6 drain");
        if (k < W) check("R6 serial bit", int'(serial_o), int'(inv[k]));
      end
      check("R6 drained to zero", int'(par_o), 0);
      check("R9 done after drain", int'(done_o), 1);

      // R7 parallel load and hold, serial input ignored
      step(2'b11, 1'b1, 1'b0, word, "R7 load");
      check("R7 word", int'(par_o), w);
      step(2'b11, 1'b0, 1'b1, inv, "R7 hold");
      step(2'b11, 1'b0, 1'b0, inv, "R7 hold");
      check("R7 held", int'(par_o), w);
      check("R10 done low", int'(done_o), 0);

      // R2 serial through; mode change restart counts this shift (R9)
      for (int k = 0; k < W; k++)
        step(2'b00, ~k[0], inv[k], word, "R2 R4 R9 serial");
      check("R2 stream in", int'(par_o), int'(inv));
      check("R9 done after serial", int'(done_o), 1);
      for (int k = 0; k < W; k++) begin
        check("R2 serial out", int'(serial_o), int'(inv[k]));
        step(2'b00, 1'b1, 1'b0, word, "R2 R4 flush");
      end
    end

    // R9 mode change mid-stream restarts count
    step(2'b01, 1'b0, 1'b1, '0, "R9 restart");
    step(2'b01, 1'b0, 1'b1, '0, "R9 count");
    step(2'b00, 1'b0, 1'b1, '0, "R9 change");
    step(2'b00, 1'b0, 1'b1, '0, "R9 count");
    step(2'b00, 1'b0, 1'b1, '0, "R9 count");
    check("R9 not yet done", int'(done_o), 0);
    step(2'b00, 1'b0, 1'b1, '0, "R9 fourth");
    check("R9 done", int'(done_o), 1);

    finished = 1'b1;
    summary();
  end

endmodule